// File: doc/BRIEF.md
# Serial-Bus EEPROM Slave Controller

This block is the slave end of a four-wire serial memory. A host holds chip select low, clocks in an 8-bit instruction and, depending on the instruction, an address byte and data bytes, and receives read data back on the serial output. Behind the bus sits a 512-byte memory and a small status register. All instructions, addresses and data travel most significant bit first in SPI mode 0.

The bus pins are oversampled by the block's own clock. A synchronizer stage feeds edge detectors, and every bus action happens on a detected serial-clock edge. Address bit 8 travels inside the READ and WRITE opcodes. Writes to the array and to the status register need a write enable latch, which a separate instruction sets. Array writes gather up to one 16-byte page and commit together when chip select rises on a byte boundary.

The memory contents are held in flip-flops and reset to zero. The status bits above the latch are stored but do not affect any access.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset, so_oe_o is low, the write enable latch is clear, a status read returns 0x00 and every memory byte reads 0x00.
- R2: Bits on si_i are taken on serial-clock rising edges, most significant bit first. The serial clock may stay low for any time in mid-byte without changing the result.
- R3: Opcode 0x06 sets the write enable latch and opcode 0x04 clears it. The latch is visible as status bit 1.
- R4: Opcode 0x05 returns the status byte {stored bits 7..2, latch, 0} and repeats it for as long as the clock runs.
- R5: Opcode 0x01 with the latch set stores bits 7..2 of the next complete byte when chip select rises on a byte boundary, and then clears the latch. Without the latch set, the store has no effect.
- R6: Opcode 0000_A011 (A = address bit 8), followed by the low address byte, streams memory bytes from that address. The 9-bit address increments after each byte and wraps from 511 to 0.
- R7: Opcode 0000_A010 with the latch set, followed by the low address byte and data bytes, writes those bytes from that address. Address bits 3..0 wrap within the 16-byte page. The bytes are committed when chip select rises after at least one complete byte, and the latch then clears.
- R8: A write opcode sent while the latch is clear changes no memory byte.
- R9: If chip select rises in the middle of a byte during a write, no byte of that write is stored and the latch stays set.
- R10: so_oe_o is high only while chip select is low.
- R11: An opcode outside the set above changes neither the memory nor the latch.
- R12: so_o changes only after a detected serial-clock falling edge. The first bit of each returned byte appears on the falling edge that follows the last rising edge of the byte before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock from the host |
| si_i | input | 1 | Serial data from the host |
| so_o | output | 1 | Serial data to the host |
| so_oe_o | output | 1 | Output enable for an external tri-state driver on so_o |

## Verification
The directed cases cover every opcode with the latch both set and clear, a write that starts mid-page and overruns the page end, a write cut off by a partial byte, an unknown opcode and a read across the top of the address space. These cases separate gating errors from addressing errors. A read with a paused serial clock and a hold check on so_o across rising edges separates the timing of sampling from the timing of shifting out. Random sequences of latch changes, page writes of 1 to 18 bytes (some with partial tails), reads and status reads run against a bench model. A final full-memory readback catches any stray or lost write.

// File: rtl/spi_eep_pkg.sv
package spi_eep_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] OP_LATCH_SET = 8'h06;
  localparam logic [7:0] OP_LATCH_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD   = 8'h05;
  localparam logic [7:0] OP_STAT_WR   = 8'h01;
  localparam logic [2:0] OP_MEM_RD_LO = 3'b011;
  localparam logic [2:0] OP_MEM_WR_LO = 3'b010;

  typedef enum logic [2:0] {
    ST_OP,
    ST_ADDR,
    ST_RDATA,
    ST_WDATA,
    ST_SRRD,
    ST_SRWR,
    ST_SKIP
  } eep_state_e;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  output logic cs_act_o,
  output logic cs_rise_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic si_o
);
  logic [STAGES-1:0] cs_q, sck_q, si_q;
  logic cs_d, sck_d;
  logic cs_s, sck_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= '1;
      sck_q <= '0;
      si_q  <= '0;
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_q  <= {cs_q[STAGES-2:0], cs_ni};
      sck_q <= {sck_q[STAGES-2:0], sck_i};
      si_q  <= {si_q[STAGES-2:0], si_i};
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign cs_s       = cs_q[STAGES-1];
  assign sck_s      = sck_q[STAGES-1];
  assign si_o       = si_q[STAGES-1];
  assign cs_act_o   = ~cs_s;
  assign cs_rise_o  = cs_s & ~cs_d;
  assign sck_rise_o = ~cs_s & sck_s & ~sck_d;
  assign sck_fall_o = ~cs_s & ~sck_s & sck_d;
endmodule

// File: rtl/spi_eep_array.sv
module spi_eep_array #(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16,
  localparam int BW        = spi_eep_pkg::BYTE_W,
  localparam int PAGE_W    = $clog2(PAGE_BYTES),
  localparam int SEL_W     = ADDR_W - PAGE_W,
  localparam int DEPTH     = 1 << ADDR_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [BW-1:0]            rd_data_o,
  input  logic                     pg_we_i,
  input  logic [SEL_W-1:0]         pg_sel_i,
  input  logic [PAGE_BYTES-1:0]    pg_mask_i,
  input  logic [PAGE_BYTES*BW-1:0] pg_data_i
);
  logic [BW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (pg_we_i) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pg_mask_i[i]) mem_q[{pg_sel_i, PAGE_W'(i)}] <= pg_data_i[i*BW +: BW];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  // R7: a page commit always carries at least one complete byte
  a_r7_commit_has_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_we_i |-> $countones(pg_mask_i) != 0);
endmodule

// File: rtl/spi_eep_ctrl.sv
module spi_eep_ctrl
  import spi_eep_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16,
  localparam int BW        = BYTE_W,
  localparam int PAGE_W    = $clog2(PAGE_BYTES),
  localparam int SEL_W     = ADDR_W - PAGE_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cs_act_i,
  input  logic                     cs_rise_i,
  input  logic                     sck_rise_i,
  input  logic                     sck_fall_i,
  input  logic                     si_i,
  output logic                     so_o,
  output logic [ADDR_W-1:0]        rd_addr_o,
  input  logic [BW-1:0]            rd_data_i,
  output logic                     pg_we_o,
  output logic [SEL_W-1:0]         pg_sel_o,
  output logic [PAGE_BYTES-1:0]    pg_mask_o,
  output logic [PAGE_BYTES*BW-1:0] pg_data_o
);
  eep_state_e state;
  logic [2:0]    bit_cnt;
  logic [BW-2:0] sh;
  logic [BW-1:0] osh, sr_pend;
  logic [BW-3:0] sr_hi;
  logic          so_q, wel, rd_mode, sr_have;
  logic [ADDR_W-1:0] addr;
  logic [PAGE_BYTES-1:0] pmask;
  logic [PAGE_BYTES-1:0][BW-1:0] pbuf;

  logic [BW-1:0]     rx_byte, status;
  logic [ADDR_W-1:0] addr_rx;
  logic              byte_done, on_boundary;

  assign rx_byte     = {sh, si_i};
  assign byte_done   = sck_rise_i && (bit_cnt == 3'd7);
  assign on_boundary = cs_rise_i && (bit_cnt == 3'd0);
  assign status      = {sr_hi, wel, 1'b0};
  assign addr_rx     = {addr[ADDR_W-1:BW], rx_byte};
  assign rd_addr_o   = (state == ST_ADDR) ? addr_rx : addr;

  assign pg_we_o   = on_boundary && (state == ST_WDATA) && (|pmask);
  assign pg_sel_o  = addr[ADDR_W-1:PAGE_W];
  assign pg_mask_o = pmask;
  assign pg_data_o = pbuf;
  assign so_o      = so_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_OP;
      bit_cnt <= '0;
      sh      <= '0;
      osh     <= '0;
      so_q    <= 1'b0;
      wel     <= 1'b0;
      rd_mode <= 1'b0;
      sr_hi   <= '0;
      sr_pend <= '0;
      sr_have <= 1'b0;
      addr    <= '0;
      pmask   <= '0;
      pbuf    <= '0;
    end else if (!cs_act_i) begin
      if (on_boundary && state == ST_WDATA && (|pmask)) wel <= 1'b0;
      if (on_boundary && state == ST_SRWR && sr_have) begin
        sr_hi <= sr_pend[BW-1:2];
        wel   <= 1'b0;
      end
      state   <= ST_OP;
      bit_cnt <= '0;
      pmask   <= '0;
      sr_have <= 1'b0;
    end else begin
      if (sck_rise_i) begin
        sh      <= rx_byte[BW-2:0];
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (byte_done) begin
        unique case (state)
          ST_OP: begin
            if (rx_byte == OP_LATCH_SET) begin
              wel   <= 1'b1;
              state <= ST_SKIP;
            end else if (rx_byte == OP_LATCH_CLR) begin
              wel   <= 1'b0;
              state <= ST_SKIP;
            end else if (rx_byte == OP_STAT_RD) begin
              osh   <= status;
              state <= ST_SRRD;
            end else if (rx_byte == OP_STAT_WR) begin
              state <= wel ? ST_SRWR : ST_SKIP;
            end else if (rx_byte[7:4] == 4'h0 && rx_byte[2:0] == OP_MEM_RD_LO) begin
              addr[ADDR_W-1] <= rx_byte[3];
              rd_mode        <= 1'b1;
              state          <= ST_ADDR;
            end else if (rx_byte[7:4] == 4'h0 && rx_byte[2:0] == OP_MEM_WR_LO && wel) begin
              addr[ADDR_W-1] <= rx_byte[3];
              rd_mode        <= 1'b0;
              state          <= ST_ADDR;
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_ADDR: begin
            if (rd_mode) begin
              osh   <= rd_data_i;
              addr  <= addr_rx + 1'b1;
              state <= ST_RDATA;
            end else begin
              addr  <= addr_rx;
              state <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            osh  <= rd_data_i;
            addr <= addr + 1'b1;
          end
          ST_WDATA: begin
            pbuf[addr[PAGE_W-1:0]]  <= rx_byte;
            pmask[addr[PAGE_W-1:0]] <= 1'b1;
            addr[PAGE_W-1:0]        <= addr[PAGE_W-1:0] + 1'b1;
          end
          ST_SRRD: osh <= status;
          ST_SRWR: begin
            sr_pend <= rx_byte;
            sr_have <= 1'b1;
          end
          default: ;
        endcase
      end
      if (sck_fall_i) begin
        so_q <= osh[BW-1];
        osh  <= {osh[BW-2:0], 1'b0};
      end
    end
  end

  // R12: serial output moves only after a detected falling edge
  a_r12_so_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sck_fall_i |=> $stable(so_q));
  // R8: a page commit happens only while the latch is set
  a_r8_write_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_we_o |-> wel);
  // R7: the latch clears once the page is committed
  a_r7_wel_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_we_o |=> !wel);
  // R10: no bus activity is decoded while deselected
  a_r10_idle_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> (bit_cnt == 3'd0) && (state == ST_OP));
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int ADDR_W      = 9,
  parameter int PAGE_BYTES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  output logic so_o,
  output logic so_oe_o
);
  localparam int BW     = spi_eep_pkg::BYTE_W;
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int SEL_W  = ADDR_W - PAGE_W;

  logic cs_act, cs_rise, sck_rise, sck_fall, si_s;
  logic [ADDR_W-1:0]        rd_addr;
  logic [BW-1:0]            rd_data;
  logic                     pg_we;
  logic [SEL_W-1:0]         pg_sel;
  logic [PAGE_BYTES-1:0]    pg_mask;
  logic [PAGE_BYTES*BW-1:0] pg_data;

  spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .si_i,
    .cs_act_o(cs_act), .cs_rise_o(cs_rise),
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .si_o(si_s)
  );

  spi_eep_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
    .clk_i, .rst_ni,
    .cs_act_i(cs_act), .cs_rise_i(cs_rise),
    .sck_rise_i(sck_rise), .sck_fall_i(sck_fall), .si_i(si_s),
    .so_o,
    .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .pg_we_o(pg_we), .pg_sel_o(pg_sel), .pg_mask_o(pg_mask), .pg_data_o(pg_data)
  );

  spi_eep_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_array (
    .clk_i, .rst_ni,
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pg_we_i(pg_we), .pg_sel_i(pg_sel), .pg_mask_i(pg_mask), .pg_data_i(pg_data)
  );

  assign so_oe_o = cs_act;
endmodule

// File: tb/spi_eeprom_slave_tb_top.sv
module spi_eeprom_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SCK_HALF   = 6;
  localparam int WD_CYCLES  = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int pause_clks = 0;
  bit hold_chk = 1'b0;

  logic [7:0] mem_m [512];
  logic       m_wel;
  logic [5:0] m_sr;
  logic [7:0] wdat [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_eeprom_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .so_o(so), .so_oe_o(so_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    cw(SCK_HALF);
  endtask

  task automatic desel();
    sck = 1'b0;
    cw(SCK_HALF);
    cs_n = 1'b1;
    cw(SCK_HALF + 4);
  endtask

  task automatic xbit(input logic b, output logic r);
    sck = 1'b0;
    si  = b;
    cw(SCK_HALF);
    r   = so;
    sck = 1'b1;
    cw(SCK_HALF);
    if (hold_chk) chk("R12 so held over rising edge", so, r);
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      if (i == 3 && pause_clks > 0) begin
        sck = 1'b0;
        cw(pause_clks);
      end
      xbit(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] rx;
    sel(); xbyte(op, rx); desel();
    if (op == 8'h06) m_wel = 1'b1;
    if (op == 8'h04) m_wel = 1'b0;
  endtask

  function automatic logic [7:0] stat_m();
    return {m_sr, m_wel, 1'b0};
  endfunction

  task automatic rdsr(input string tag, input int reps);
    logic [7:0] rx;
    sel();
    chk("R10 oe high while selected", so_oe, 1'b1);
    xbyte(8'h05, rx);
    for (int k = 0; k < reps; k++) begin
      xbyte(8'h00, rx);
      chk(tag, rx, stat_m());
    end
    desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] rx;
    sel(); xbyte(8'h01, rx); xbyte(v, rx); desel();
    if (m_wel) begin
      m_sr  = v[7:2];
      m_wel = 1'b0;
    end
  endtask

  task automatic rd_mem(input string tag, input logic [8:0] a, input int n);
    logic [7:0] rx;
    sel();
    xbyte({4'h0, a[8], 3'b011}, rx);
    xbyte(a[7:0], rx);
    for (int k = 0; k < n; k++) begin
      logic [8:0] ix;
      ix = a + 9'(k);
      xbyte(8'h00, rx);
      chk(tag, rx, mem_m[ix]);
    end
    desel();
  endtask

  // partial > 0 appends that many extra bits after the data bytes
  task automatic wr_mem(input logic [8:0] a, input int n, input int partial);
    logic [7:0] rx;
    logic r;
    sel();
    xbyte({4'h0, a[8], 3'b010}, rx);
    xbyte(a[7:0], rx);
    for (int k = 0; k < n; k++) xbyte(wdat[k], rx);
    for (int k = 0; k < partial; k++) xbit(1'b1, r);
    desel();
    if (m_wel && n > 0 && partial == 0) begin
      for (int k = 0; k < n; k++) begin
        logic [8:0] ix;
        ix = {a[8:4], 4'(a[3:0] + 4'(k))};
        mem_m[ix] = wdat[k];
      end
      m_wel = 1'b0;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    void'($urandom(32'h5eed_0c0d));
    for (int i = 0; i < 512; i++) mem_m[i] = 8'h00;
    m_wel = 1'b0;
    m_sr  = '0;
    cw(5);
    rst_n = 1'b1;
    cw(5);

    // reset state
    chk("R1 oe low after reset", so_oe, 1'b0);
    rdsr("R1 R4 status after reset", 1);
    rd_mem("R1 memory zero after reset", 9'h000, 4);

    // write without latch
    for (int k = 0; k < 4; k++) wdat[k] = 8'hA0 + 8'(k);
    wr_mem(9'h020, 4, 0);
    rd_mem("R8 write ignored without latch", 9'h020, 4);

    // latch set and clear
    cmd1(8'h06);
    rdsr("R3 latch set", 1);
    cmd1(8'h04);
    rdsr("R3 latch cleared", 1);

    // page write starting mid-page, overrunning the page end
    cmd1(8'h06);
    for (int k = 0; k < 10; k++) wdat[k] = 8'h30 + 8'(k);
    wr_mem(9'h10A, 10, 0);
    rdsr("R7 latch cleared after write", 1);
    rd_mem("R7 page wrap write", 9'h100, 17);

    // partial trailing byte discards the write
    cmd1(8'h06);
    for (int k = 0; k < 3; k++) wdat[k] = 8'h5A ^ 8'(k);
    wr_mem(9'h1F0, 3, 5);
    rdsr("R9 latch kept after partial", 1);
    rd_mem("R9 partial write discarded", 9'h1F0, 4);

    // unknown opcode with latch set
    sel(); xbyte(8'h9A, rx); xbyte(8'h00, rx); xbyte(8'h77, rx); desel();
    rdsr("R11 latch unchanged after unknown op", 1);
    rd_mem("R11 memory unchanged after unknown op", 9'h000, 2);

    // status write
    wrsr(8'hFF);
    rdsr("R5 R4 status write stored and repeated", 3);
    wrsr(8'h00);
    rdsr("R5 status write ignored without latch", 1);
    cmd1(8'h06);
    wrsr(8'h24);
    rdsr("R5 status write second value", 1);

    // top-of-memory read wrap
    cmd1(8'h06);
    wdat[0] = 8'hE1; wdat[1] = 8'hE2;
    wr_mem(9'h1FE, 2, 0);
    cmd1(8'h06);
    wdat[0] = 8'h11; wdat[1] = 8'h22;
    wr_mem(9'h000, 2, 0);
    rd_mem("R6 read wraps 511 to 0", 9'h1FE, 4);

    // paused clock and output hold across rising edges
    pause_clks = 40;
    hold_chk   = 1'b1;
    rd_mem("R2 R12 read with paused clock", 9'h104, 3);
    pause_clks = 0;
    hold_chk   = 1'b0;
    chk("R10 oe low after deselect", so_oe, 1'b0);

    // random mix
    for (int it = 0; it < 20; it++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0, 1: cmd1(8'h06);
        2: begin
          int n, p;
          logic [8:0] a;
          n = $urandom_range(1, 18);
          p = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0;
          a = 9'($urandom_range(0, 511));
          for (int k = 0; k < n; k++) wdat[k] = 8'($urandom);
          wr_mem(a, n, p);
        end
        3: rd_mem("R6 R7 random read", 9'($urandom_range(0, 511)), $urandom_range(1, 8));
        4: rdsr("R3 R4 random status", 1);
        default: cmd1(8'h04);
      endcase
    end

    rd_mem("R7 R8 full readback", 9'h000, 512);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule